// File: doc/BRIEF.md
# Serial Flash Block-Erase Command Decoder

This block is the device side of a serial flash, reduced to its block-erase path. The SPI pins are sampled and synchronised into the system clock domain. The block collects an opcode and a 24-bit address while chip-select is low, and the command is only acted on when chip-select returns high. Two erase sizes exist: a 32 KB half block and a full 64 KB block. Either one sets every byte of the chosen region to FFH in a small behavioural array. The erase runs for a fixed number of clock cycles, and a busy flag is high for that whole time.

An erase is accepted only if the write-enable latch was set beforehand by its own command and the target 64 KB block is not locked. The latch clears when an erase finishes or is refused. While the block is busy it ignores every command except the status read. The array is scaled down: each modeled 32 KB half holds `HALF_BYTES` bytes, and only enough address bits to pick one of `NUM_B64` blocks are decoded. Higher address bits wrap. A combinational read port exposes the array so that its contents can be inspected.

Top module: `spi_erase_decoder`

## Requirements
- R1: After reset, busy is 0, the write-enable latch is 0 and array byte i holds i XOR 5AH. Array index layout is {block, A15, offset}.
- R2: Opcode 06H followed by a chip-select rise after exactly 8 bits sets the write-enable latch. Opcode 05H returns the status byte {6'b0, latch (bit 1), busy (bit 0)} MSB first on so, with changes on sck falling edges. so_oe is high only during that data phase.
- R3: Opcode 52H plus 24 address bits (MSB first, exactly 32 bits) erases the half selected by block bits A[16 +: log2 NUM_B64] and A15 to FFH. Lower address bits are don't-care, higher bits wrap, and the other half is untouched.
- R4: Opcode D8H plus 24 address bits erases both halves of the selected block. A15 and the lower bits are don't-care.
- R5: busy rises on the 3rd clock edge after cs_n goes high and stays high for exactly ERASE_CYC cycles. The array holds FFH from the edge where busy falls.
- R6: An erase with the write-enable latch clear changes nothing and busy stays 0.
- R7: An erase aimed at a block whose blk_lock bit is 1 changes nothing, busy stays 0 and the write-enable latch is cleared. Other blocks remain erasable.
- R8: The write-enable latch is 0 after an erase completes.
- R9: A chip-select rise after a bit count other than 32 (erase) or 8 (write-enable) aborts the command. There is no erase and the latch is unchanged.
- R10: While busy, the status read reports busy=1 and an erase command is ignored.
- R11: The same commands work with sck idling high (mode 3) as with sck idling low (mode 0).
- R12: No erase starts while cs_n stays low, even after a full 32-bit command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | SPI serial clock |
| cs_n | input | 1 | SPI chip-select, active low |
| si | input | 1 | SPI serial data in |
| so | output | 1 | SPI serial data out, valid when so_oe is high |
| so_oe | output | 1 | Output enable for so (high impedance otherwise) |
| blk_lock | input | NUM_B64 | Protection bit per modeled 64 KB block |
| busy | output | 1 | Erase in progress |
| rd_addr | input | AW | Array inspection address |
| rd_data | output | 8 | Array byte at rd_addr (combinational) |

## Verification
Every SPI pin passes through two synchroniser stages, so a command takes effect on the 3rd clock edge after cs_n rises. The bench checks busy at the sample points just before and just after that edge, and again on both sides of the edge ERASE_CYC cycles later. A status bit is driven on so within three clocks of the sck falling edge, and the bench reads it a full half SPI period later, just before the next rising edge. Array contents are read through the combinational port only after busy is known to have dropped. Refused and aborted commands are judged from the full array and from a status read taken afterwards.

// File: rtl/spi_ers_pkg.sv
package spi_ers_pkg;

    localparam logic [7:0] OP_WREN       = 8'h06;
    localparam logic [7:0] OP_RDSR       = 8'h05;
    localparam logic [7:0] OP_ERASE_HALF = 8'h52;
    localparam logic [7:0] OP_ERASE_FULL = 8'hD8;

    localparam int CNT_W = 7;

    typedef enum logic [1:0] {
        CMD_NONE,
        CMD_WREN,
        CMD_ERASE
    } cmd_kind_e;

    typedef struct packed {
        logic        full;
        logic [23:0] addr;
    } erase_req_t;

    function automatic cmd_kind_e classify(logic [CNT_W-1:0] nbits, logic [31:0] word);
        if (nbits == CNT_W'(8) && word[7:0] == OP_WREN)
            return CMD_WREN;
        if (nbits == CNT_W'(32) &&
            (word[31:24] == OP_ERASE_HALF || word[31:24] == OP_ERASE_FULL))
            return CMD_ERASE;
        return CMD_NONE;
    endfunction

    function automatic logic [7:0] status_byte(logic wel, logic busy);
        return {6'b0, wel, busy};
    endfunction

    function automatic logic [7:0] fill_pattern(logic [7:0] idx);
        return idx ^ 8'h5A;
    endfunction

endpackage

// File: rtl/spi_ers_sync.sv
module spi_ers_sync #(
    parameter int         WIDTH   = 3,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] level,
    output logic [WIDTH-1:0] rise,
    output logic [WIDTH-1:0] fall
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic s1_q, s2_q, prev_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                s1_q   <= RST_VAL[b];
                s2_q   <= RST_VAL[b];
                prev_q <= RST_VAL[b];
            end else begin
                s1_q   <= din[b];
                s2_q   <= s1_q;
                prev_q <= s2_q;
            end
        end

        assign level[b] = s2_q;
        assign rise[b]  = s2_q & ~prev_q;
        assign fall[b]  = ~s2_q & prev_q;
    end

endmodule

// File: rtl/spi_ers_shifter.sv
module spi_ers_shifter
    import spi_ers_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_s,
    input  logic             sck_rise,
    input  logic             sck_fall,
    input  logic             si_s,
    input  logic             wel,
    input  logic             busy,
    output logic [CNT_W-1:0] bit_cnt,
    output logic [31:0]      word,
    output logic             so,
    output logic             so_oe
);

    logic [CNT_W-1:0] cnt_q;
    logic [31:0]      word_q;
    logic [7:0]       sout_q;
    logic             reading_q;
    logic             load_stat;

    assign load_stat = (reading_q || (cnt_q == CNT_W'(8) && word_q[7:0] == OP_RDSR))
                       && (cnt_q[2:0] == 3'd0);

    always_ff @(posedge clk) begin
        if (rst || cs_s) begin
            cnt_q     <= '0;
            word_q    <= '0;
            sout_q    <= '0;
            reading_q <= 1'b0;
        end else begin
            if (sck_rise) begin
                word_q <= {word_q[30:0], si_s};
                if (cnt_q != '1)
                    cnt_q <= cnt_q + CNT_W'(1);
            end
            if (sck_fall) begin
                if (load_stat) begin
                    sout_q    <= status_byte(wel, busy);
                    reading_q <= 1'b1;
                end else if (reading_q) begin
                    sout_q <= {sout_q[6:0], 1'b0};
                end
            end
        end
    end

    assign bit_cnt = cnt_q;
    assign word    = word_q;
    assign so      = sout_q[7];
    assign so_oe   = reading_q;

    // R2
    oe_idle_chk: assert property (@(posedge clk) disable iff (rst)
        cs_s |=> !so_oe);

endmodule

// File: rtl/spi_ers_ctrl.sv
module spi_ers_ctrl
    import spi_ers_pkg::*;
#(
    parameter int NUM_B64   = 4,
    parameter int ERASE_CYC = 1000,
    localparam int BW = (NUM_B64 > 1) ? $clog2(NUM_B64) : 1,
    localparam int TW = $clog2(ERASE_CYC + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cs_rise,
    input  logic [CNT_W-1:0]   bit_cnt,
    input  logic [31:0]        word,
    input  logic [NUM_B64-1:0] blk_lock,
    output logic               busy,
    output logic               wel,
    output logic               erase_fire,
    output erase_req_t         erase_req
);

    cmd_kind_e   kind;
    logic        lock_hit;
    logic        busy_q, wel_q;
    logic [TW-1:0] cnt_q;
    erase_req_t  req_q;

    assign kind       = classify(bit_cnt, word);
    assign lock_hit   = blk_lock[word[16 +: BW]];
    assign erase_fire = busy_q && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            wel_q  <= 1'b0;
            cnt_q  <= '0;
            req_q  <= '0;
        end else if (busy_q) begin
            if (erase_fire) begin
                busy_q <= 1'b0;
                wel_q  <= 1'b0;
            end else begin
                cnt_q <= cnt_q - TW'(1);
            end
        end else if (cs_rise) begin
            case (kind)
                CMD_WREN:  wel_q <= 1'b1;
                CMD_ERASE: begin
                    if (wel_q) begin
                        if (lock_hit) begin
                            wel_q <= 1'b0;
                        end else begin
                            busy_q     <= 1'b1;
                            cnt_q      <= TW'(ERASE_CYC - 1);
                            req_q.full <= (word[31:24] == OP_ERASE_FULL);
                            req_q.addr <= word[23:0];
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign busy      = busy_q;
    assign wel       = wel_q;
    assign erase_req = req_q;

    // R12
    start_on_cs_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_q) |-> $past(cs_rise));

    // R6
    start_needs_wel_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_q) |-> $past(wel_q));

    // R7
    start_unlocked_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_q) |-> !$past(lock_hit));

    // R8
    wel_clear_on_done_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_q) |-> !wel_q);

    // R5
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_q && cnt_q != '0) |=> busy_q);

endmodule

// File: rtl/spi_ers_array.sv
module spi_ers_array
    import spi_ers_pkg::*;
#(
    parameter int NUM_B64    = 4,
    parameter int HALF_BYTES = 8,
    localparam int BW         = (NUM_B64 > 1) ? $clog2(NUM_B64) : 1,
    localparam int NUM_HALVES = 2 * NUM_B64,
    localparam int DEPTH      = NUM_HALVES * HALF_BYTES,
    localparam int OW         = $clog2(HALF_BYTES),
    localparam int AW         = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          erase_fire,
    input  erase_req_t    erase_req,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);

    logic [7:0]            mem [DEPTH];
    logic [NUM_HALVES-1:0] half_hit;

    for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
        assign half_hit[h] = (erase_req.addr[16 +: BW] == BW'(h / 2)) &&
                             (erase_req.full || (erase_req.addr[15] == 1'(h % 2)));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= fill_pattern(8'(i));
        end else if (erase_fire) begin
            for (int i = 0; i < DEPTH; i++)
                if (half_hit[i >> OW])
                    mem[i] <= 8'hFF;
        end
    end

    assign rd_data = mem[rd_addr];

    // R4
    full_covers_pair_chk: assert property (@(posedge clk) disable iff (rst)
        (erase_fire && erase_req.full) |-> ($countones(half_hit) == 2));

    // R3
    half_single_chk: assert property (@(posedge clk) disable iff (rst)
        (erase_fire && !erase_req.full) |-> $onehot0(half_hit) && (half_hit != '0));

endmodule

// File: rtl/spi_erase_decoder.sv
module spi_erase_decoder
    import spi_ers_pkg::*;
#(
    parameter int NUM_B64    = 4,
    parameter int HALF_BYTES = 8,
    parameter int ERASE_CYC  = 1000,
    localparam int AW = $clog2(2 * NUM_B64 * HALF_BYTES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sck,
    input  logic               cs_n,
    input  logic               si,
    output logic               so,
    output logic               so_oe,
    input  logic [NUM_B64-1:0] blk_lock,
    output logic               busy,
    input  logic [AW-1:0]      rd_addr,
    output logic [7:0]         rd_data
);

    logic [2:0]       sy_lvl, sy_rise, sy_fall;
    logic [CNT_W-1:0] bit_cnt;
    logic [31:0]      word;
    logic             wel, erase_fire;
    erase_req_t       erase_req;
    logic             unused_sync;

    spi_ers_sync #(.WIDTH(3), .RST_VAL(3'b100)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .din   ({cs_n, sck, si}),
        .level (sy_lvl),
        .rise  (sy_rise),
        .fall  (sy_fall)
    );

    assign unused_sync = ^{sy_lvl[1], sy_rise[0], sy_fall[2], sy_fall[0]};

    spi_ers_shifter u_shift (
        .clk      (clk),
        .rst      (rst),
        .cs_s     (sy_lvl[2]),
        .sck_rise (sy_rise[1]),
        .sck_fall (sy_fall[1]),
        .si_s     (sy_lvl[0]),
        .wel      (wel),
        .busy     (busy),
        .bit_cnt  (bit_cnt),
        .word     (word),
        .so       (so),
        .so_oe    (so_oe)
    );

    spi_ers_ctrl #(.NUM_B64(NUM_B64), .ERASE_CYC(ERASE_CYC)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .cs_rise    (sy_rise[2]),
        .bit_cnt    (bit_cnt),
        .word       (word),
        .blk_lock   (blk_lock),
        .busy       (busy),
        .wel        (wel),
        .erase_fire (erase_fire),
        .erase_req  (erase_req)
    );

    spi_ers_array #(.NUM_B64(NUM_B64), .HALF_BYTES(HALF_BYTES)) u_array (
        .clk        (clk),
        .rst        (rst),
        .erase_fire (erase_fire),
        .erase_req  (erase_req),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data)
    );

endmodule

// File: tb/test_spi_erase_decoder.sv
`timescale 1ns/1ps
module test_spi_erase_decoder;

    localparam int NB    = 4;
    localparam int HB    = 8;
    localparam int EC    = 1500;
    localparam int HALF  = 8;
    localparam int DEPTH = 2 * NB * HB;
    localparam int AW    = $clog2(DEPTH);
    localparam int NV    = 8;

    // {wren, opcode, addr, lock, expected erased-half mask}
    localparam logic [44:0] VEC [NV] = '{
        {1'b1, 8'h52, 24'h018000, 4'h0, 8'h08},  // R3
        {1'b1, 8'h52, 24'h027FFF, 4'h0, 8'h10},  // R3 low bits ignored
        {1'b1, 8'hD8, 24'h038123, 4'h0, 8'hC0},  // R4
        {1'b1, 8'hD8, 24'h000000, 4'h0, 8'h03},  // R4
        {1'b0, 8'hD8, 24'h010000, 4'h0, 8'h00},  // R6
        {1'b1, 8'h52, 24'h020000, 4'h4, 8'h00},  // R7
        {1'b1, 8'hD8, 24'h010000, 4'hD, 8'h0C},  // R7 other blocks locked
        {1'b1, 8'h52, 24'hFE8000, 4'h0, 8'h20}   // R3 high bits wrap
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sck = 1'b0;
    logic          cs_n = 1'b1;
    logic          si = 1'b0;
    logic [NB-1:0] lock = '0;
    logic [AW-1:0] rd_addr = '0;
    logic          so, so_oe, busy;
    logic [7:0]    rd_data;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    spi_erase_decoder #(.NUM_B64(NB), .HALF_BYTES(HB), .ERASE_CYC(EC)) i_spi_erase_decoder (
        .clk      (clk),
        .rst      (rst),
        .sck      (sck),
        .cs_n     (cs_n),
        .si       (si),
        .so       (so),
        .so_oe    (so_oe),
        .blk_lock (lock),
        .busy     (busy),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wait_clk(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1; cs_n = 1'b1; sck = 1'b0; si = 1'b0;
        wait_clk(3);
        rst = 1'b0;
        wait_clk(2);
    endtask

    task automatic cs_low(bit m3);
        sck = m3;
        wait_clk(HALF);
        cs_n = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic shift(logic [39:0] d, int n, bit m3, output logic [7:0] rx);
        rx = '0;
        for (int i = 0; i < n; i++) begin
            if (m3) sck = 1'b0;
            si = d[n-1-i];
            wait_clk(HALF);
            rx = {rx[6:0], so};
            sck = 1'b1;
            wait_clk(HALF);
            if (!m3) sck = 1'b0;
        end
    endtask

    task automatic send(logic [39:0] d, int n, bit m3);
        logic [7:0] r;
        cs_low(m3);
        shift(d, n, m3, r);
        wait_clk(HALF);
        cs_n = 1'b1;
        wait_clk(6);
    endtask

    task automatic read_status(bit m3, output logic [7:0] st, output logic oe_pre);
        logic [7:0] r;
        cs_low(m3);
        oe_pre = so_oe;
        shift(40'h05, 8, m3, r);
        shift(40'h00, 8, m3, st);
        wait_clk(HALF);
        cs_n = 1'b1;
        wait_clk(6);
    endtask

    task automatic check_mem(string req, logic [7:0] mask);
        int bad = 0;
        logic [7:0] first_act = '0;
        logic [7:0] first_exp = '0;
        int first_at = 0;
        for (int i = 0; i < DEPTH; i++) begin
            logic [7:0] e;
            rd_addr = AW'(i);
            #1;
            e = mask[i / HB] ? 8'hFF : (8'(i) ^ 8'h5A);
            if (rd_data !== e) begin
                if (bad == 0) begin
                    first_act = rd_data; first_exp = e; first_at = i;
                end
                bad++;
            end
        end
        checks++;
        if (bad != 0) begin
            fails++;
            $display("FAIL %s array byte %0d (%0d bad): actual %0h expected %0h",
                     req, first_at, bad, first_act, first_exp);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin : main
        logic [7:0] st;
        logic oe;

        // R1 reset state
        do_reset();
        check("R1", busy, 0, "busy after reset");
        read_status(1'b0, st, oe);
        check("R1", st, 8'h00, "status after reset");
        check_mem("R1", 8'h00);

        // R2 write-enable and status read
        send(40'h06, 8, 1'b0);
        read_status(1'b0, st, oe);
        check("R2", st, 8'h02, "status after write-enable");
        check("R2", oe, 0, "so_oe before data phase");
        check("R2", so_oe, 0, "so_oe after cs_n high");

        // Table of erase commands: R3/R4/R6/R7
        for (int v = 0; v < NV; v++) begin
            logic [44:0] e;
            e = VEC[v];
            do_reset();
            lock = e[11:8];
            if (e[44]) send(40'h06, 8, 1'b0);
            send({8'h00, e[43:36], e[35:12]}, 32, 1'b0);
            wait_clk(EC + 10);
            check("R3/R4/R6/R7", busy, 0, "busy after table vector");
            check_mem("R3/R4/R6/R7 table", e[7:0]);
        end
        lock = '0;

        // R7 latch cleared on a refused erase
        do_reset();
        lock = 4'b0001;
        send(40'h06, 8, 1'b0);
        send({8'h00, 8'hD8, 24'h000000}, 32, 1'b0);
        check("R7", busy, 0, "busy on locked block");
        read_status(1'b0, st, oe);
        check("R7", st, 8'h00, "status after refused erase");
        check_mem("R7", 8'h00);
        lock = '0;

        // R9 write-enable with nine bits is ignored
        do_reset();
        send(40'h00D, 9, 1'b0);
        read_status(1'b0, st, oe);
        check("R9", st, 8'h00, "status after 9-bit write-enable");

        // R9 truncated erase aborts, latch kept
        send(40'h06, 8, 1'b0);
        send(40'hD80100, 24, 1'b0);
        check("R9", busy, 0, "busy after truncated erase");
        read_status(1'b0, st, oe);
        check("R9", st, 8'h02, "status after truncated erase");
        check_mem("R9", 8'h00);

        // R12 and R5 exact busy timing
        do_reset();
        send(40'h06, 8, 1'b0);
        begin
            logic [7:0] r;
            cs_low(1'b0);
            shift({8'h00, 8'hD8, 24'h010000}, 32, 1'b0, r);
        end
        wait_clk(20);
        check("R12", busy, 0, "busy with cs_n still low");
        cs_n = 1'b1;
        wait_clk(2);
        check("R5", busy, 0, "busy two edges after cs_n high");
        wait_clk(1);
        check("R5", busy, 1, "busy three edges after cs_n high");
        wait_clk(EC - 1);
        check("R5", busy, 1, "busy on last erase cycle");
        wait_clk(1);
        check("R5", busy, 0, "busy after erase time");
        check_mem("R5", 8'h0C);

        // R10 and R8 behaviour while busy
        do_reset();
        send(40'h06, 8, 1'b0);
        send({8'h00, 8'h52, 24'h000000}, 32, 1'b0);
        read_status(1'b0, st, oe);
        check("R10", st, 8'h03, "status during erase");
        send({8'h00, 8'hD8, 24'h030000}, 32, 1'b0);
        check("R10", busy, 1, "busy still set after ignored erase");
        wait_clk(EC);
        check("R10", busy, 0, "busy after erase time");
        read_status(1'b0, st, oe);
        check("R8", st, 8'h00, "status after completed erase");
        check_mem("R10", 8'h01);

        // R11 mode 3
        do_reset();
        send(40'h06, 8, 1'b1);
        read_status(1'b1, st, oe);
        check("R11", st, 8'h02, "mode 3 status after write-enable");
        send({8'h00, 8'h52, 24'h038000}, 32, 1'b1);
        wait_clk(EC + 10);
        check_mem("R11", 8'h80);
        read_status(1'b1, st, oe);
        check("R11", st, 8'h00, "mode 3 status after erase");

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule